// File: doc/BRIEF.md
# Carry-Preserving Decrement Flag Unit

This block takes an operand, subtracts one from it at a chosen width of 8, 16, 32 or 64 bits, and returns the result together with a new six-bit status-flag vector. Only the bits inside the chosen width are decremented; any bits above them are passed to the result unchanged. This lets an execution pipeline update a byte, word, doubleword or quadword loop counter in place.

The carry flag is copied straight from the incoming flag vector, so a running multi-word borrow chain survives the decrement. The other five flags are recomputed from the operand and the result at the chosen width: overflow, sign, zero, half-carry (borrow out of the low nibble) and parity of the low byte. The arithmetic is combinational. By default one register stage holds the result and flags, giving a latency of one clock cycle. Setting `OUT_REG` to 0 removes that stage.

Top module: `decr_flag_unit`

## Requirements
- R1: The low W bits of `resultOut` equal the low W bits of `opIn` minus one, modulo 2^W. W is 8, 16, 32 or 64 for `widthSel` equal to 0, 1, 2 or 3.
- R2: Bits of `resultOut` at or above W equal the same bits of `opIn`.
- R3: Flag bit 0 (carry) of `flagsOut` equals flag bit 0 of `flagsIn`, whatever the operand.
- R4: Flag bit 5 (overflow) is 1 exactly when the low W bits of `opIn` hold the most negative signed W-bit value, that is, bit W-1 set and all lower bits clear.
- R5: Flag bit 4 (sign) equals bit W-1 of `resultOut`.
- R6: Flag bit 3 (zero) is 1 exactly when the low W bits of `resultOut` are all zero. Bits above W have no effect on it.
- R7: Flag bit 2 (half-carry) is 1 exactly when `opIn[3:0]` is zero, which marks a borrow out of bit 3.
- R8: Flag bit 1 (parity) is 1 exactly when `resultOut[7:0]` holds an even number of ones, at every width.
- R9: When the low W bits of `opIn` are zero, the low W bits of the result are all ones, sign is 1 and zero is 0.
- R10: With `OUT_REG` = 1, the outputs show the result for the inputs present at the previous rising clock edge. While `rstN` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opIn | input | 64 | Operand to decrement |
| widthSel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| flagsIn | input | 6 | Current flags; bit 0 is carry |
| resultOut | output | 64 | Decremented operand with upper bits kept |
| flagsOut | output | 6 | Bit 0 carry, 1 parity, 2 half-carry, 3 zero, 4 sign, 5 overflow |

## Verification
The datapath holds no state between operations. A wrong width decode or a wrong lane mask therefore shows up within one cycle of the inputs. It appears as upper bits of `resultOut` that change when they should be kept, or as sign and zero flags taken from the wrong bit range. Random operands are biased toward zero low lanes and minimum signed values. This matters because overflow, zero and the all-ones wrap each appear only at those boundaries, and uniform values would almost never reach them. A carry flag that tracks anything other than its input shows up on the first check in which the operand's borrow and the incoming carry disagree.

// File: rtl/decr_pkg.sv
package decr_pkg;
  // Operand widths are BASE_W shifted left by the lane index
  parameter int BASE_W    = 8;
  parameter int NUM_SIZES = 4;
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1);
  localparam int SEL_W    = $clog2(NUM_SIZES);
  localparam int PAR_W    = 8;
  localparam int NIB_W    = 4;

  // Flag vector layout
  localparam int FLAG_W     = 6;
  localparam int FLG_CARRY  = 0;
  localparam int FLG_PARITY = 1;
  localparam int FLG_HALF   = 2;
  localparam int FLG_ZERO   = 3;
  localparam int FLG_SIGN   = 4;
  localparam int FLG_OVF    = 5;

  typedef struct packed {
    logic [NUM_SIZES-1:0] laneHot;  // one-hot operand width strobe
  } ctrlStrobes_t;
endpackage

// File: rtl/decr_control.sv
module decr_control
  import decr_pkg::*;
(
  input  logic [SEL_W-1:0] widthSel,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes = '0;
    strobes.laneHot[widthSel] = 1'b1;
  end
endmodule

// File: rtl/decr_datapath.sv
module decr_datapath
  import decr_pkg::*;
(
  input  logic [DATA_W-1:0] opIn,
  input  ctrlStrobes_t      strobes,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultComb,
  output logic [FLAG_W-1:0] flagsComb
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] diff;
  logic [NUM_SIZES-1:0][DATA_W-1:0] laneMask;
  logic [NUM_SIZES-1:0] laneSign, laneZero, laneOvf;

  assign diff = opIn - DATA_W'(1);

  // One lane per supported width
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
    localparam int W = BASE_W << i;
    localparam logic [DATA_W-1:0] MIN_NEG = DATA_W'(1) << (W - 1);
    assign laneMask[i] = ALL_ONES >> (DATA_W - W);
    assign laneSign[i] = diff[W-1];
    assign laneZero[i] = ((diff & laneMask[i]) == '0);
    assign laneOvf[i]  = ((opIn & laneMask[i]) == MIN_NEG);
  end

  logic [DATA_W-1:0] selMask;
  logic selSign, selZero, selOvf;

  always_comb begin
    selMask = '0;
    selSign = 1'b0;
    selZero = 1'b0;
    selOvf  = 1'b0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (strobes.laneHot[k]) begin
        selMask = selMask | laneMask[k];
        selSign = selSign | laneSign[k];
        selZero = selZero | laneZero[k];
        selOvf  = selOvf  | laneOvf[k];
      end
    end
  end

  assign resultComb = (opIn & ~selMask) | (diff & selMask);

  always_comb begin
    flagsComb             = '0;
    flagsComb[FLG_CARRY]  = flagsIn[FLG_CARRY];
    flagsComb[FLG_PARITY] = ~^resultComb[PAR_W-1:0];
    flagsComb[FLG_HALF]   = (opIn[NIB_W-1:0] == '0);
    flagsComb[FLG_ZERO]   = selZero;
    flagsComb[FLG_SIGN]   = selSign;
    flagsComb[FLG_OVF]    = selOvf;
  end
endmodule

// File: rtl/decr_flag_unit.sv
module decr_flag_unit
  import decr_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opIn,
  input  logic [SEL_W-1:0]  widthSel,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] resultComb;
  logic [FLAG_W-1:0] flagsComb;

  decr_control u_ctrl (
    .widthSel (widthSel),
    .strobes  (strobes)
  );

  decr_datapath u_dp (
    .opIn       (opIn),
    .strobes    (strobes),
    .flagsIn    (flagsIn),
    .resultComb (resultComb),
    .flagsComb  (flagsComb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultOut <= '0;
        flagsOut  <= '0;
      end else begin
        resultOut <= resultComb;
        flagsOut  <= flagsComb;
      end
    end
  end else begin : g_comb
    assign resultOut = resultComb;
    assign flagsOut  = flagsComb;
  end
endmodule

// File: rtl/decr_checker.sv
module decr_checker
  import decr_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opIn,
  input logic [SEL_W-1:0]  widthSel,
  input logic [FLAG_W-1:0] flagsIn,
  input logic [DATA_W-1:0] resultOut,
  input logic [FLAG_W-1:0] flagsOut
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  if (OUT_REG) begin : g_chk
    // R3
    carry_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> flagsOut[FLG_CARRY] == $past(flagsIn[FLG_CARRY]));

    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (armed && $past(widthSel) == '0) |->
        resultOut[DATA_W-1:BASE_W] == $past(opIn[DATA_W-1:BASE_W]));

    // R7
    half_borrow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (armed && $past(opIn[NIB_W-1:0]) == '0) |-> flagsOut[FLG_HALF]);

    // R8
    parity_even_chk: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> flagsOut[FLG_PARITY] == ~^resultOut[PAR_W-1:0]);

    // R6
    zero_sign_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      (armed && flagsOut[FLG_ZERO]) |-> !flagsOut[FLG_SIGN]);

    // R4
    ovf_positive_chk: assert property (@(posedge clk) disable iff (!rstN)
      (armed && flagsOut[FLG_OVF]) |-> (!flagsOut[FLG_SIGN] && !flagsOut[FLG_ZERO]));
  end
endmodule

bind decr_flag_unit decr_checker #(.OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opIn      (opIn),
  .widthSel  (widthSel),
  .flagsIn   (flagsIn),
  .resultOut (resultOut),
  .flagsOut  (flagsOut)
);

// File: tb/decr_flag_unit_tb.sv
module decr_flag_unit_tb;
  import decr_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] opIn = '0;
  logic [SEL_W-1:0]  widthSel = '0;
  logic [FLAG_W-1:0] flagsIn = '0;
  logic [DATA_W-1:0] resultOut;
  logic [FLAG_W-1:0] flagsOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  decr_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opIn(opIn), .widthSel(widthSel),
    .flagsIn(flagsIn), .resultOut(resultOut), .flagsOut(flagsOut)
  );

  function automatic int widthOf(logic [SEL_W-1:0] s);
    return 8 << s;
  endfunction

  function automatic logic [63:0] maskOf(logic [SEL_W-1:0] s);
    return (widthOf(s) == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << widthOf(s)) - 64'd1);
  endfunction

  function automatic logic [63:0] expResult(logic [63:0] op, logic [SEL_W-1:0] s);
    logic [63:0] m = maskOf(s);
    return (op & ~m) | ((op - 64'd1) & m);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic apply(logic [63:0] op, logic [SEL_W-1:0] s, logic [FLAG_W-1:0] f);
    logic [63:0] m, r;
    int w;
    @(negedge clk);
    opIn = op; widthSel = s; flagsIn = f;
    @(negedge clk);
    m = maskOf(s); w = widthOf(s); r = expResult(op, s);
    chk("R1 low lanes", resultOut & m, r & m);
    chk("R2 upper bits", resultOut & ~m, op & ~m);
    chk("R3 carry", 64'(flagsOut[FLG_CARRY]), 64'(f[FLG_CARRY]));
    chk("R4 overflow", 64'(flagsOut[FLG_OVF]), 64'((op & m) == (64'd1 << (w - 1))));
    chk("R5 sign", 64'(flagsOut[FLG_SIGN]), 64'(r[w-1]));
    chk("R6 zero", 64'(flagsOut[FLG_ZERO]), 64'((r & m) == 64'd0));
    chk("R7 half", 64'(flagsOut[FLG_HALF]), 64'(op[3:0] == 4'd0));
    chk("R8 parity", 64'(flagsOut[FLG_PARITY]), 64'(~^r[7:0]));
    if ((op & m) == 64'd0) begin
      chk("R9 all ones", resultOut & m, m);
      chk("R9 sign set", 64'(flagsOut[FLG_SIGN]), 64'd1);
      chk("R9 zero clear", 64'(flagsOut[FLG_ZERO]), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [63:0] op;
    logic [SEL_W-1:0] s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset result", resultOut, 64'd0);
    chk("R10 reset flags", 64'(flagsOut), 64'd0);
    rstN = 1'b1;

    // Directed corners at every width
    for (int i = 0; i < NUM_SIZES; i++) begin
      s = SEL_W'(i);
      apply(64'hA5A5_A5A5_A5A5_A5A5 & ~maskOf(s), s, 6'b000001);  // R9 zero lane
      apply(64'h0000_0000_0000_0000, s, 6'b000000);
      apply((64'd1 << (widthOf(s) - 1)) | 64'hF0F0_0000_0000_0000 & ~maskOf(s), s, 6'b111111); // R4
      apply(64'd1, s, 6'b000000);                                  // R6 result zero
      apply(64'hFFFF_FFFF_FFFF_FFF0, s, 6'b000001);                // R7
    end
    // R6: lane zero with non-zero upper bits
    apply(64'h1234_5678_9ABC_0001, 2'd0, 6'b0);
    apply(64'h1234_5678_0000_0001, 2'd1, 6'b0);

    // R10 latency: change input, output must still hold prior value before edge
    @(negedge clk);
    opIn = 64'd5; widthSel = 2'd3; flagsIn = '0;
    @(negedge clk);
    opIn = 64'd9;
    #1;
    chk("R10 one-cycle latency", resultOut, 64'd4);
    @(negedge clk);
    chk("R10 next capture", resultOut, 64'd8);

    // Constrained random
    for (int n = 0; n < 2000; n++) begin
      s = SEL_W'($urandom_range(0, NUM_SIZES - 1));
      op = {$urandom, $urandom};
      case ($urandom_range(0, 7))
        0: op = op & ~maskOf(s);
        1: op = (op & ~maskOf(s)) | (64'd1 << (widthOf(s) - 1));
        2: op = (op & ~maskOf(s)) | 64'd1;
        3: op = op & ~64'hF;
        default: ;
      endcase
      apply(op, s, FLAG_W'($urandom));
    end
    finishRun();
  end
endmodule